// File: doc/BRIEF.md
# Configurable Burst Read Timing Controller

This block times the synchronous read path of a memory device. A 16-bit configuration word sets the read mode, the first-data latency, the level and timing of a ready output, and how a burst steps through word addresses. When synchronous reads are enabled and chip enable is high, an address-valid strobe latches a start address. The controller then counts clock edges until the programmed latency expires. It raises a data-valid strobe and presents the word address to the array. On every later edge it advances that address until the burst ends or chip enable drops.

Bursts come in three shapes. A continuous burst runs without bound. A wrapped burst of 8 or 16 words cycles inside the aligned block that holds the start address. A linear burst of 8 or 16 words delivers exactly that many words and then stops. Reserved latency and burst-length codes are refused field by field and raise a sticky error flag. Reserved bits of the configuration word always read back their fixed values.

Top module: `burst_read_timer`

## Requirements
- R1: After a synchronous reset the configuration reads 16'hAFC8 (asynchronous mode, latency code 5, ready active high and coincident with data, wrap on, continuous burst), the error flag is 0, data_valid is 0 and rdy is 0.
- R2: With bit 15 = 0 and latency code c in bits 13:11 (1 to 7), data_valid first rises after the (c+2)-th rising edge, counting the edge that sampled address-valid with chip enable high as edge 0.
- R3: Bit 8 = 1 makes rdy go active on the same edge as data_valid. Bit 8 = 0 makes it go active one edge earlier. In both cases rdy stays active while data_valid is high.
- R4: Bit 10 gives the active level of rdy (1 = high, 0 = low), and rdy sits at the opposite level whenever it is inactive, including when idle.
- R5: The first data_valid cycle presents the latched start address on word_addr, and each following data_valid cycle presents the next word address of the burst.
- R6: With bit 3 = 1 and burst code 3'b010 (8 words) or 3'b011 (16 words), the address increments inside the aligned 8- or 16-word block and wraps to its start, and the burst continues until chip enable falls.
- R7: With burst code 3'b000 (continuous), the address increments across any block boundary. data_valid is 0 after the first edge that samples chip enable low.
- R8: With bit 3 = 0 and burst code 3'b010 or 3'b011, data_valid stays high for exactly 8 or 16 cycles with linearly increasing addresses, then falls.
- R9: While burst code bits 2:0 read 3'b000, bit 3 of the configuration readback reads 1.
- R10: A write carrying latency code 3'b000, or a burst code other than 3'b000, 3'b010 or 3'b011, leaves that field unchanged and sets the error flag. The flag stays set until reset.
- R11: Bits 14, 5 and 4 always read 0 and bits 9, 7 and 6 always read 1, whatever is written.
- R12: With bit 15 = 1 (asynchronous mode), address-valid starts no burst: data_valid stays 0 and rdy stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| cfg_err | output | 1 | Sticky flag set by a reserved-code write |
| ce | input | 1 | Chip enable, active high |
| avd | input | 1 | Address-valid strobe, active high |
| start_addr | input | AW | Burst start word address |
| word_addr | output | AW | Current word address of the burst |
| data_valid | output | 1 | High in cycles that carry a burst word |
| rdy | output | 1 | Ready, level set by configuration bit 10 |

## Verification
The checker assumes that the configuration is not rewritten while a burst is pending or running. Ready polarity and the burst shape are read live by its properties, so a write in mid-burst would break the link between data_valid and the rdy level. The stimulus therefore performs every configuration write with chip enable low and leaves at least one idle edge before the next address-valid strobe. It also keeps address-valid to a single cycle per burst, so no property has to reason about a restart in mid-burst.

// File: rtl/brt_pkg.sv
package brt_pkg;

  localparam int CFG_W = 16;

  // Field positions of the configuration word
  localparam int B_ASYNC  = 15;
  localparam int LAT_HI   = 13;
  localparam int LAT_LO   = 11;
  localparam int B_POL    = 10;
  localparam int B_PHASE  = 8;
  localparam int B_WRAP   = 3;
  localparam int BL_HI    = 2;
  localparam int BL_LO    = 0;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'hAFC8;
  // Reserved bits: 14, 9, 7, 6, 5, 4
  localparam logic [CFG_W-1:0] RSVD_MASK = 16'h42F0;

  localparam logic [2:0] BL_CONT = 3'b000;
  localparam logic [2:0] BL_8    = 3'b010;
  localparam logic [2:0] BL_16   = 3'b011;

  localparam int MAX_BURST = 16;
  localparam int LEFT_W    = $clog2(MAX_BURST);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_BURST = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       async_mode;
    logic [2:0] lat;
    logic       rdy_high;
    logic       rdy_with_data;
    logic       wrap;
    logic [2:0] blen;
  } rd_cfg_t;

  function automatic logic lat_code_ok(input logic [2:0] c);
    return c != 3'b000;
  endfunction

  function automatic logic blen_code_ok(input logic [2:0] c);
    return (c == BL_CONT) || (c == BL_8) || (c == BL_16);
  endfunction

  function automatic logic [LEFT_W-1:0] burst_last(input logic [2:0] c);
    return (c == BL_16) ? LEFT_W'(15) : LEFT_W'(7);
  endfunction

endpackage

// File: rtl/brt_cfg_reg.sv
module brt_cfg_reg
  import brt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output rd_cfg_t          cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             err
);

  logic       async_q;
  logic [2:0] lat_q;
  logic       pol_q;
  logic       phase_q;
  logic       wrap_q;
  logic [2:0] blen_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      async_q <= CFG_RESET[B_ASYNC];
      lat_q   <= CFG_RESET[LAT_HI:LAT_LO];
      pol_q   <= CFG_RESET[B_POL];
      phase_q <= CFG_RESET[B_PHASE];
      wrap_q  <= CFG_RESET[B_WRAP];
      blen_q  <= CFG_RESET[BL_HI:BL_LO];
      err_q   <= 1'b0;
    end else if (we) begin
      async_q <= wdata[B_ASYNC];
      pol_q   <= wdata[B_POL];
      phase_q <= wdata[B_PHASE];
      wrap_q  <= wdata[B_WRAP];
      if (lat_code_ok(wdata[LAT_HI:LAT_LO])) lat_q <= wdata[LAT_HI:LAT_LO];
      else                                   err_q <= 1'b1;
      if (blen_code_ok(wdata[BL_HI:BL_LO]))  blen_q <= wdata[BL_HI:BL_LO];
      else                                   err_q <= 1'b1;
    end
  end

  // Continuous burst forces the wrap bit to read as set
  logic wrap_eff;
  assign wrap_eff = wrap_q | (blen_q == BL_CONT);

  logic [CFG_W-1:0] field_bits;
  always_comb begin
    field_bits                  = '0;
    field_bits[B_ASYNC]         = async_q;
    field_bits[LAT_HI:LAT_LO]   = lat_q;
    field_bits[B_POL]           = pol_q;
    field_bits[B_PHASE]         = phase_q;
    field_bits[B_WRAP]          = wrap_eff;
    field_bits[BL_HI:BL_LO]     = blen_q;
  end

  assign rdata = field_bits | (CFG_RESET & RSVD_MASK);
  assign err   = err_q;

  assign cfg.async_mode    = async_q;
  assign cfg.lat           = lat_q;
  assign cfg.rdy_high      = pol_q;
  assign cfg.rdy_with_data = phase_q;
  assign cfg.wrap          = wrap_eff;
  assign cfg.blen          = blen_q;

endmodule

// File: rtl/brt_latency_seq.sv
module brt_latency_seq
  import brt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  rd_cfg_t    cfg,
  input  logic       ce,
  input  logic       avd,
  output logic       latch,
  output logic       dv,
  output logic       rdy,
  output logic [2:0] blen_cap,
  output logic       wrap_cap
);

  seq_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [LEFT_W-1:0] left_q, left_n;
  logic              dv_q, dv_n;
  logic              act_q, act_n;
  logic              rdy_q, rdy_n;
  logic              lead_q;
  logic [2:0]        blen_q;
  logic              wrap_q;

  logic sync_on;
  logic linear_burst;
  assign sync_on      = ~cfg.async_mode;
  assign latch        = sync_on & ce & avd;
  assign linear_burst = ~wrap_q & (blen_q != BL_CONT);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    left_n = left_q;
    dv_n   = dv_q;
    act_n  = act_q;
    if (!sync_on || !ce) begin
      st_n  = SEQ_IDLE;
      dv_n  = 1'b0;
      act_n = 1'b0;
    end else if (avd) begin
      st_n  = SEQ_WAIT;
      cnt_n = CNT_W'(cfg.lat) + CNT_W'(2);
      dv_n  = 1'b0;
      act_n = 1'b0;
    end else begin
      unique case (st_q)
        SEQ_WAIT: begin
          if (cnt_q == CNT_W'(1)) begin
            st_n   = SEQ_BURST;
            dv_n   = 1'b1;
            act_n  = 1'b1;
            left_n = burst_last(blen_q);
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
            act_n = lead_q & (cnt_q == CNT_W'(2));
          end
        end
        SEQ_BURST: begin
          if (linear_burst) begin
            if (left_q == '0) begin
              st_n  = SEQ_IDLE;
              dv_n  = 1'b0;
              act_n = 1'b0;
            end else begin
              left_n = left_q - LEFT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
    rdy_n = act_n ? cfg.rdy_high : ~cfg.rdy_high;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      dv_q   <= 1'b0;
      act_q  <= 1'b0;
      rdy_q  <= ~CFG_RESET[B_POL];
      lead_q <= 1'b0;
      blen_q <= CFG_RESET[BL_HI:BL_LO];
      wrap_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      left_q <= left_n;
      dv_q   <= dv_n;
      act_q  <= act_n;
      rdy_q  <= rdy_n;
      if (latch) begin
        lead_q <= ~cfg.rdy_with_data;
        blen_q <= cfg.blen;
        wrap_q <= cfg.wrap;
      end
    end
  end

  assign dv       = dv_q;
  assign rdy      = rdy_q;
  assign blen_cap = blen_q;
  assign wrap_cap = wrap_q;

endmodule

// File: rtl/brt_addr_gen.sv
module brt_addr_gen
  import brt_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          adv,
  input  logic [2:0]    blen,
  input  logic          wrap,
  output logic [AW-1:0] addr
);

  localparam int W8  = $clog2(8);
  localparam int W16 = $clog2(16);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  always_comb begin
    mask = '1;
    if (wrap) begin
      if (blen == BL_8)  mask = AW'((1 << W8) - 1);
      if (blen == BL_16) mask = AW'((1 << W16) - 1);
    end
    inc = (addr_q & ~mask) | ((addr_q + AW'(1)) & mask);
  end

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= start;
    else if (adv)  addr_q <= inc;
  end

  assign addr = addr_q;

endmodule

// File: rtl/burst_read_timer.sv
module burst_read_timer
  import brt_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             cfg_err,
  input  logic             ce,
  input  logic             avd,
  input  logic [AW-1:0]    start_addr,
  output logic [AW-1:0]    word_addr,
  output logic             data_valid,
  output logic             rdy
);

  rd_cfg_t    cfg;
  logic       latch;
  logic       dv;
  logic [2:0] blen_cap;
  logic       wrap_cap;

  brt_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata),
    .err   (cfg_err)
  );

  brt_latency_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .ce       (ce),
    .avd      (avd),
    .latch    (latch),
    .dv       (dv),
    .rdy      (rdy),
    .blen_cap (blen_cap),
    .wrap_cap (wrap_cap)
  );

  brt_addr_gen #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .load  (latch),
    .start (start_addr),
    .adv   (dv & ce & ~latch),
    .blen  (blen_cap),
    .wrap  (wrap_cap),
    .addr  (word_addr)
  );

  assign data_valid = dv;

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic          avd,
  input logic [15:0]   cfg_rdata,
  input logic          cfg_err,
  input logic [AW-1:0] word_addr,
  input logic          data_valid,
  input logic          rdy
);

  // R1: state right after a reset edge
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (cfg_rdata == 16'hAFC8) && !cfg_err && !data_valid);

  // R3 and R4: ready is at its active level while data is valid
  a_r3_rdy_with_data: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (rdy == cfg_rdata[10]));

  // R5 and R7: continuous burst steps by one word
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (data_valid && $past(data_valid) && $past(ce) && !$past(avd) && cfg_rdata[2:0] == 3'b000)
      |-> word_addr == $past(word_addr) + AW'(1));

  // R6: 16-word wrap never leaves the aligned block
  a_r6_wrap16_block: assert property (@(posedge clk) disable iff (rst)
    (data_valid && $past(data_valid) && cfg_rdata[3] && cfg_rdata[2:0] == 3'b011)
      |-> word_addr[AW-1:4] == $past(word_addr[AW-1:4]));

  // R7: chip enable low ends the burst
  a_r7_ce_abort: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !data_valid);

  // R9: continuous burst reads the wrap bit as set
  a_r9_wrap_forced: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[2:0] == 3'b000) |-> cfg_rdata[3]);

  // R10: error flag is sticky and latency code 000 is never held
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  a_r10_no_rsvd_lat: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[13:11] != 3'b000);

  // R11: reserved bits fixed
  a_r11_rsvd_fixed: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[9] && cfg_rdata[7] && cfg_rdata[6] && !cfg_rdata[14] && !cfg_rdata[5] && !cfg_rdata[4]);

  // R12: asynchronous mode keeps data_valid low
  a_r12_async_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[15] |=> !data_valid);

endmodule

bind burst_read_timer brt_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce         (ce),
  .avd        (avd),
  .cfg_rdata  (cfg_rdata),
  .cfg_err    (cfg_err),
  .word_addr  (word_addr),
  .data_valid (data_valid),
  .rdy        (rdy)
);

// File: tb/sim_burst_read_timer.sv
module sim_burst_read_timer;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  // Vector: code[12:10] lead[9] pol[8] dv_edge[7:4] rdy_edge[3:0]
  localparam logic [12:0] VECS [0:13] = '{
    {3'd1, 1'b0, 1'b1, 4'd3, 4'd3}, {3'd1, 1'b1, 1'b0, 4'd3, 4'd2},
    {3'd2, 1'b0, 1'b0, 4'd4, 4'd4}, {3'd2, 1'b1, 1'b1, 4'd4, 4'd3},
    {3'd3, 1'b0, 1'b1, 4'd5, 4'd5}, {3'd3, 1'b1, 1'b0, 4'd5, 4'd4},
    {3'd4, 1'b0, 1'b0, 4'd6, 4'd6}, {3'd4, 1'b1, 1'b1, 4'd6, 4'd5},
    {3'd5, 1'b0, 1'b1, 4'd7, 4'd7}, {3'd5, 1'b1, 1'b0, 4'd7, 4'd6},
    {3'd6, 1'b0, 1'b0, 4'd8, 4'd8}, {3'd6, 1'b1, 1'b1, 4'd8, 4'd7},
    {3'd7, 1'b0, 1'b1, 4'd9, 4'd9}, {3'd7, 1'b1, 1'b0, 4'd9, 4'd8}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          cfg_err;
  logic          ce = 1'b0;
  logic          avd = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] word_addr;
  logic          data_valid;
  logic          rdy;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] got [0:31];
  int got_n;
  int first_dv, first_rdy;
  logic [2:0] code;
  logic lead, pol;
  logic [15:0] tmp;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_read_timer #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .ce(ce), .avd(avd),
    .start_addr(start_addr), .word_addr(word_addr),
    .data_valid(data_valid), .rdy(rdy)
  );

  function automatic logic [15:0] mk(input logic async_m, input logic [2:0] lat,
                                     input logic p, input logic phase,
                                     input logic wrap, input logic [2:0] bl);
    return {async_m, 1'b0, lat, p, 1'b1, phase, 4'b1100, wrap, bl};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic launch(input logic [AW-1:0] a);
    @(negedge clk); ce = 1'b1; avd = 1'b1; start_addr = a;
    @(posedge clk);
    @(negedge clk); avd = 1'b0;
  endtask

  task automatic stop_burst();
    @(negedge clk); ce = 1'b0;
    @(posedge clk); #1;
    chk(!data_valid, "R7 dv after ce low", 32'(data_valid), 0);
    @(negedge clk);
  endtask

  task automatic collect(input logic [AW-1:0] a, input int edges);
    got_n = 0;
    launch(a);
    for (int k = 1; k <= edges; k++) begin
      @(posedge clk); #1;
      if (data_valid) begin
        if (got_n < 32) got[got_n] = word_addr;
        got_n++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 16'hAFC8, "R1 reset cfg", 32'(cfg_rdata), 32'hAFC8);
    chk(!cfg_err, "R1 reset err", 32'(cfg_err), 0);
    chk(!data_valid, "R1 reset dv", 32'(data_valid), 0);
    chk(!rdy, "R1 reset rdy", 32'(rdy), 0);

    // Latency and ready timing table (R2, R3, R4)
    for (int i = 0; i < 14; i++) begin
      code = VECS[i][12:10];
      lead = VECS[i][9];
      pol  = VECS[i][8];
      wr(mk(1'b0, code, pol, ~lead, 1'b1, 3'b000));
      chk(rdy == ~pol, "R4 idle rdy level", 32'(rdy), 32'(~pol));
      launch(24'h000040);
      first_dv = 0; first_rdy = 0;
      for (int k = 1; k <= 12; k++) begin
        @(posedge clk); #1;
        if (data_valid && first_dv == 0) first_dv = k;
        if (rdy == pol && first_rdy == 0) first_rdy = k;
      end
      chk(first_dv == int'(VECS[i][7:4]), "R2 first dv edge", 32'(first_dv), 32'(VECS[i][7:4]));
      chk(first_rdy == int'(VECS[i][3:0]), "R3 first rdy edge", 32'(first_rdy), 32'(VECS[i][3:0]));
      chk(rdy == pol, "R3 rdy held in burst", 32'(rdy), 32'(pol));
      stop_burst();
    end

    // R9: wrap bit written 0 with continuous reads 1
    wr(mk(1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'b000));
    chk(cfg_rdata[3], "R9 wrap reads 1", 32'(cfg_rdata[3]), 1);

    // R11: inverted reserved bits are ignored
    tmp = mk(1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 3'b010);
    wr(tmp ^ 16'h42F0);
    chk(cfg_rdata == tmp, "R11 reserved fixed", 32'(cfg_rdata), 32'(tmp));
    chk(!cfg_err, "R11 no err", 32'(cfg_err), 0);

    // R10: reserved latency and burst codes
    wr(mk(1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 3'b010));
    chk(cfg_rdata[13:11] == 3'd4, "R10 lat kept", 32'(cfg_rdata[13:11]), 4);
    chk(cfg_err, "R10 err set", 32'(cfg_err), 1);
    wr(mk(1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 3'b100));
    chk(cfg_rdata[2:0] == 3'b010, "R10 blen kept", 32'(cfg_rdata[2:0]), 2);
    chk(cfg_rdata[13:11] == 3'd1, "R10 lat accepted", 32'(cfg_rdata[13:11]), 1);
    wr(mk(1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 3'b000));
    chk(cfg_err, "R10 err sticky", 32'(cfg_err), 1);

    // R5, R6: 8-word wrap
    wr(mk(1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 3'b010));
    collect(24'h000105, 16);
    chk(got_n == 14, "R6 wrap8 word count", 32'(got_n), 14);
    chk(got[0] == 24'h000105, "R5 first addr", 32'(got[0]), 32'h105);
    for (int j = 0; j < 14; j++)
      chk(got[j] == (24'h000100 | AW'((5 + j) & 7)), "R6 wrap8 addr", 32'(got[j]),
          32'(24'h000100 | AW'((5 + j) & 7)));
    stop_burst();

    // R6: 16-word wrap
    wr(mk(1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 3'b011));
    collect(24'h00023A, 24);
    chk(got_n == 21, "R6 wrap16 word count", 32'(got_n), 21);
    for (int j = 0; j < 21; j++)
      chk(got[j] == (24'h000230 | AW'((10 + j) & 15)), "R6 wrap16 addr", 32'(got[j]),
          32'(24'h000230 | AW'((10 + j) & 15)));
    stop_burst();

    // R5, R7: continuous across block boundary
    wr(mk(1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 3'b000));
    collect(24'h0000FD, 24);
    chk(got_n == 22, "R7 cont word count", 32'(got_n), 22);
    for (int j = 0; j < 22; j++)
      chk(got[j] == 24'h0000FD + AW'(j), "R5 cont addr", 32'(got[j]), 32'(24'h0000FD + j));
    stop_burst();

    // R8: linear 8 and 16 words
    wr(mk(1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 3'b010));
    collect(24'h000006, 30);
    chk(got_n == 8, "R8 linear8 count", 32'(got_n), 8);
    for (int j = 0; j < 8; j++)
      chk(got[j] == 24'h000006 + AW'(j), "R8 linear8 addr", 32'(got[j]), 32'(6 + j));
    chk(rdy == 1'b0, "R8 rdy inactive after end", 32'(rdy), 0);
    stop_burst();
    wr(mk(1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'b011));
    collect(24'h00001C, 30);
    chk(got_n == 16, "R8 linear16 count", 32'(got_n), 16);
    chk(got[15] == 24'h00002B, "R8 linear16 last addr", 32'(got[15]), 32'h2B);
    stop_burst();

    // R12: asynchronous mode ignores address-valid
    wr(mk(1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 3'b000));
    launch(24'h000010);
    first_dv = 0; first_rdy = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #1;
      if (data_valid) first_dv++;
      if (rdy) first_rdy++;
    end
    chk(first_dv == 0, "R12 async no dv", 32'(first_dv), 0);
    chk(first_rdy == 0, "R12 async rdy inactive", 32'(first_rdy), 0);
    stop_burst();

    // R1: reset again restores defaults and clears error
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 16'hAFC8, "R1 re-reset cfg", 32'(cfg_rdata), 32'hAFC8);
    chk(!cfg_err, "R1 re-reset err", 32'(cfg_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule